// File: doc/BRIEF.md
# Translation-Buffer Pointer Generator

This block holds the base and configuration registers that locate software-managed translation tables in memory, and turns a tag-access value (virtual page bits plus a 13-bit context number) into the byte address of the table entry that may hold the matching translation. There are two sides, instruction and data. Each side has one register set for context zero and one for every other context. Each set holds two base registers, one per page-size slot, and one configuration register.

A miss handler loads the tag-access value on `tag_access`. It then reads one of four pointers through the register port: data slot 0, data slot 1, instruction slot 0 or instruction slot 1. Whether the tag's context field is zero selects the register set. The page-size code of the chosen slot decides how far the tag is shifted before it indexes the table. A split flag in the base register reserves the upper half of the table for slot 1. Reads return their data one clock after the request. Fetching the table entry is left to the caller.

Top module: `tsb_ptr_gen`

## Requirements
- R1: After reset, `rd_data` is zero and every one of the twelve configuration registers reads back as zero.
- R2: A write with `wr_addr[4]`=0 stores `wr_data` in register {side=`wr_addr[3]`, set=`wr_addr[2]` (1 = nonzero context), kind=`wr_addr[1:0]`}, where kind 0 is slot-0 base, 1 is slot-1 base and 2 is config. A read with `rd_en` high places the addressed value on `rd_data` after the next rising edge. `rd_data` holds its value while `rd_en` is low.
- R3: A write with kind 3, or with `wr_addr[4]`=1, changes no register, and a register read with kind 3 returns zero.
- R4: The context-zero set is used when `tag_access[12:0]` is zero. The nonzero-context set is used otherwise.
- R5: A pointer read (`rd_addr[4]`=1, side=`rd_addr[3]` with 0 = data and 1 = instruction, slot=`rd_addr[0]`) returns bits 63:13 equal to the selected slot base's bits 63:13, except for the bits set by R6 and R7. Bits 3:0 are always zero.
- R6: With table size S = base[3:0] and page code P = config[2:0] for slot 0 or config[10:8] for slot 1, the value `tag_access` >> (9 + 3·P) is masked to bits 12+S down to 4 and OR-ed into the pointer.
- R7: For slot 1, when base bit 12 (split) is set, pointer bit 13+S is forced to one. Slot 0 ignores the split flag.
- R8: The data and instruction sides use separate register sets, so a pointer for one side does not depend on the other side's registers.
- R9: When a write and a read fall in the same cycle, the read returns the contents from before the write, and the write takes effect for the following reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tag_access | input | 64 | Tag-access value: page bits above, context in bits 12:0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (see R2, R3) |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read address: register (bit 4 = 0) or pointer (bit 4 = 1) |
| rd_data | output | 64 | Registered read data |

## Verification
A register write and a pointer read can fall in the same cycle, and the pointer can depend on the very base or config register being written. The bench provokes this by writing a new base to data context-zero slot 0 in the same clock as it reads that pointer with a zero-context tag. It judges the returned value against the pointer computed from the old register contents, and judges the read that follows against the new contents. The sweep over table sizes, page codes, slots, split and both contexts then shows that no other register set leaks into the result.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  // Address decode of the register port
  localparam int ADDR_W      = 5;
  localparam int A_PTR_BIT   = 4;  // 1: pointer read
  localparam int A_SIDE_BIT  = 3;  // 0: data, 1: instruction
  localparam int A_SET_BIT   = 2;  // 0: context zero, 1: nonzero context
  localparam int A_SLOT_BIT  = 0;  // pointer slot in pointer space

  // Fixed field positions of the tag and base registers
  localparam int CTX_W       = 13;
  localparam int SPLIT_POS   = 12;
  localparam int IDX_LSB     = 4;
  localparam int SHIFT_BASE  = 9;

  // Position of the slot-1 page code in the config register
  localparam int PS1_LSB     = 8;

  localparam int N_SIDES     = 2;
  localparam int N_SETS      = 2 * N_SIDES;
  localparam int N_KINDS     = 3;
  localparam int N_REGS      = N_SETS * N_KINDS;

  typedef enum logic [1:0] {
    KIND_BASE0 = 2'd0,
    KIND_BASE1 = 2'd1,
    KIND_CFG   = 2'd2,
    KIND_RSVD  = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/tsb_cfg_regs.sv
module tsb_cfg_regs
  import tsb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SZ_W   = 4,
  parameter int PS_W   = 3,
  localparam int HI_W  = DATA_W - CTX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             raw_rd_o,
  output logic [N_SETS-1:0][HI_W-1:0]   base_hi_o [2],
  output logic [N_SETS-1:0]             split_o,
  output logic [N_SETS-1:0][SZ_W-1:0]   sz_o [2],
  output logic [N_SETS-1:0][PS_W-1:0]   ps_o [2]
);

  localparam int IDX_W = $clog2(N_REGS);

  logic [N_REGS-1:0][DATA_W-1:0] regs_q;
  logic [N_REGS-1:0][DATA_W-1:0] regs_d;
  logic                          wr_hit;
  logic [IDX_W-1:0]              wr_idx;
  logic [IDX_W-1:0]              rd_idx;
  reg_kind_e                     wr_kind;
  reg_kind_e                     rd_kind;

  function automatic logic [IDX_W-1:0] reg_index(input logic side,
                                                 input logic set_nz,
                                                 input logic [1:0] kind);
    int unsigned v;
    v = ({31'd0, side} * 2 + {31'd0, set_nz}) * N_KINDS + {30'd0, kind};
    return IDX_W'(v);
  endfunction

  // Write decode
  always_comb begin
    wr_kind = reg_kind_e'(wr_addr[1:0]);
    wr_hit  = wr_en && !wr_addr[A_PTR_BIT] && (wr_kind != KIND_RSVD);
    wr_idx  = reg_index(wr_addr[A_SIDE_BIT], wr_addr[A_SET_BIT], wr_addr[1:0]);
  end

  // Next state
  always_comb begin
    regs_d = regs_q;
    if (wr_hit) begin
      regs_d[wr_idx] = wr_data;
    end
  end

  // Register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_hit) begin
      regs_q <= regs_d;
    end
  end

  // Raw register read (pointer space handled at the top)
  always_comb begin
    rd_kind  = reg_kind_e'(rd_addr[1:0]);
    rd_idx   = reg_index(rd_addr[A_SIDE_BIT], rd_addr[A_SET_BIT], rd_addr[1:0]);
    raw_rd_o = '0;
    if (rd_kind != KIND_RSVD) begin
      raw_rd_o = regs_q[rd_idx];
    end
  end

  // Field extraction per set and slot
  for (genvar gs = 0; gs < N_SETS; gs++) begin : g_set
    localparam int B0 = gs * N_KINDS + int'(KIND_BASE0);
    localparam int B1 = gs * N_KINDS + int'(KIND_BASE1);
    localparam int CF = gs * N_KINDS + int'(KIND_CFG);
    assign base_hi_o[0][gs] = regs_q[B0][DATA_W-1:CTX_W];
    assign base_hi_o[1][gs] = regs_q[B1][DATA_W-1:CTX_W];
    assign sz_o[0][gs]      = regs_q[B0][SZ_W-1:0];
    assign sz_o[1][gs]      = regs_q[B1][SZ_W-1:0];
    assign split_o[gs]      = regs_q[B1][SPLIT_POS];
    assign ps_o[0][gs]      = regs_q[CF][PS_W-1:0];
    assign ps_o[1][gs]      = regs_q[CF][PS1_LSB+PS_W-1:PS1_LSB];
  end

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> regs_q[$past(wr_idx)] == $past(wr_data));

  // R3
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(regs_q));

endmodule

// File: rtl/tsb_ptr_calc.sv
module tsb_ptr_calc
  import tsb_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SZ_W     = 4,
  parameter int PS_W     = 3,
  parameter bit IS_SLOT1 = 1'b0,
  localparam int HI_W    = DATA_W - CTX_W,
  localparam int SH_W    = $clog2(DATA_W) + 2,
  localparam int MAX_SZ  = DATA_W - CTX_W - 1
) (
  input  logic [DATA_W-1:0] tag_i,
  input  logic [HI_W-1:0]   hi_z_i,
  input  logic [HI_W-1:0]   hi_nz_i,
  input  logic              split_z_i,
  input  logic              split_nz_i,
  input  logic [SZ_W-1:0]   sz_z_i,
  input  logic [SZ_W-1:0]   sz_nz_i,
  input  logic [PS_W-1:0]   ps_z_i,
  input  logic [PS_W-1:0]   ps_nz_i,
  output logic [DATA_W-1:0] ptr_o
);

  logic              ctx_zero;
  logic [HI_W-1:0]   hi_sel;
  logic              split_sel;
  logic [SZ_W-1:0]   sz_raw;
  logic [PS_W-1:0]   ps_sel;
  logic [SH_W-1:0]   sz_eff;
  logic [SH_W-1:0]   top_pos;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] idx_val;
  logic [DATA_W-1:0] idx_mask;
  logic [DATA_W-1:0] split_bit;

  // Set selection on the context field
  always_comb begin
    ctx_zero  = (tag_i[CTX_W-1:0] == '0);
    hi_sel    = ctx_zero ? hi_z_i    : hi_nz_i;
    split_sel = ctx_zero ? split_z_i : split_nz_i;
    sz_raw    = ctx_zero ? sz_z_i    : sz_nz_i;
    ps_sel    = ctx_zero ? ps_z_i    : ps_nz_i;
  end

  // Table size, saturated so the split bit stays inside the word
  always_comb begin
    if (SH_W'(sz_raw) > SH_W'(MAX_SZ)) begin
      sz_eff = SH_W'(MAX_SZ);
    end else begin
      sz_eff = SH_W'(sz_raw);
    end
    top_pos = SH_W'(CTX_W) + sz_eff;
    shamt   = SH_W'(SHIFT_BASE) + SH_W'(3) * SH_W'(ps_sel);
  end

  // Index field and split bit
  always_comb begin
    idx_val   = tag_i >> shamt;
    idx_mask  = ((DATA_W'(1) << top_pos) - DATA_W'(1)) &
                ~((DATA_W'(1) << IDX_LSB) - DATA_W'(1));
    split_bit = '0;
    if (IS_SLOT1 && split_sel) begin
      split_bit = DATA_W'(1) << top_pos;
    end
    ptr_o = {hi_sel, {CTX_W{1'b0}}} | (idx_val & idx_mask) | split_bit;
  end

endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SZ_W   = 4,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tag_access,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [4:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int HI_W = DATA_W - CTX_W;
  localparam int N_PTR = N_SIDES * 2;

  logic [1:0]                rst_ff;
  logic                      rst_sync_n;
  logic [DATA_W-1:0]         raw_rd;
  logic [N_SETS-1:0][HI_W-1:0] base_hi [2];
  logic [N_SETS-1:0]         split_v;
  logic [N_SETS-1:0][SZ_W-1:0] sz_v [2];
  logic [N_SETS-1:0][PS_W-1:0] ps_v [2];
  logic [N_PTR-1:0][DATA_W-1:0] ptr_all;
  logic [DATA_W-1:0]         rd_d;
  logic [DATA_W-1:0]         rd_q;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff <= 2'b00;
    end else begin
      rst_ff <= {rst_ff[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_ff[1];

  tsb_cfg_regs #(
    .DATA_W (DATA_W),
    .SZ_W   (SZ_W),
    .PS_W   (PS_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .raw_rd_o  (raw_rd),
    .base_hi_o (base_hi),
    .split_o   (split_v),
    .sz_o      (sz_v),
    .ps_o      (ps_v)
  );

  // One calculator per side and slot
  for (genvar gd = 0; gd < N_SIDES; gd++) begin : g_side
    for (genvar gp = 0; gp < 2; gp++) begin : g_slot
      localparam int SZ_SET = gd * 2;
      localparam int NZ_SET = gd * 2 + 1;
      tsb_ptr_calc #(
        .DATA_W   (DATA_W),
        .SZ_W     (SZ_W),
        .PS_W     (PS_W),
        .IS_SLOT1 (gp == 1)
      ) u_calc (
        .tag_i      (tag_access),
        .hi_z_i     (base_hi[gp][SZ_SET]),
        .hi_nz_i    (base_hi[gp][NZ_SET]),
        .split_z_i  (split_v[SZ_SET]),
        .split_nz_i (split_v[NZ_SET]),
        .sz_z_i     (sz_v[gp][SZ_SET]),
        .sz_nz_i    (sz_v[gp][NZ_SET]),
        .ps_z_i     (ps_v[gp][SZ_SET]),
        .ps_nz_i    (ps_v[gp][NZ_SET]),
        .ptr_o      (ptr_all[gd*2+gp])
      );

      // R7
      split_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (gp == 1 && split_v[gd*2 + int'(tag_access[CTX_W-1:0] != '0)] &&
         (int'(sz_v[1][gd*2 + int'(tag_access[CTX_W-1:0] != '0)]) < HI_W))
        |-> ptr_all[gd*2+gp][CTX_W + int'(sz_v[1][gd*2 + int'(tag_access[CTX_W-1:0] != '0)])]);
    end
  end

  // Read data: next state
  always_comb begin
    if (rd_addr[A_PTR_BIT]) begin
      rd_d = ptr_all[{rd_addr[A_SIDE_BIT], rd_addr[A_SLOT_BIT]}];
    end else begin
      rd_d = raw_rd;
    end
  end

  // Read data: register with enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_data));

  // R5
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_addr[A_PTR_BIT]) |=> (rd_data[IDX_LSB-1:0] == '0));

endmodule

// File: tb/tsb_ptr_gen_tb.sv
module tsb_ptr_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic [63:0] tag_access;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;

  int tests;
  int fails;
  logic [63:0] lcg;
  logic [63:0] shadow [12];
  bit          done;

  tsb_ptr_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_access (tag_access),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg ^ (lcg >> 29);
  endfunction

  function automatic int sidx(input int side, input int set_nz, input int kind);
    return (side * 2 + set_nz) * 3 + kind;
  endfunction

  function automatic logic [4:0] raddr(input int side, input int set_nz, input int kind);
    return {1'b0, side[0], set_nz[0], kind[1:0]};
  endfunction

  function automatic logic [4:0] paddr(input int side, input int slot);
    return {1'b1, side[0], 2'b00, slot[0]};
  endfunction

  // Expected pointer from the requirement arithmetic (R4..R8)
  function automatic logic [63:0] exp_ptr(input int side, input int slot,
                                          input logic [63:0] tag);
    int          set_nz;
    logic [63:0] base;
    logic [63:0] cfg;
    int          s;
    int          p;
    logic [63:0] r;
    set_nz = (tag[12:0] == 13'd0) ? 0 : 1;
    base   = shadow[sidx(side, set_nz, slot)];
    cfg    = shadow[sidx(side, set_nz, 2)];
    s      = int'(base[3:0]);
    p      = (slot == 1) ? int'(cfg[10:8]) : int'(cfg[2:0]);
    r      = {base[63:13], 13'd0};
    r      = r | ((tag >> (9 + 3 * p)) & (((64'd1 << (13 + s)) - 64'd1) & ~64'hF));
    if (slot == 1 && base[12]) r = r | (64'd1 << (13 + s));
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [63:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic set_reg(input int side, input int set_nz, input int kind,
                         input logic [63:0] d);
    do_write(raddr(side, set_nz, kind), d);
    shadow[sidx(side, set_nz, kind)] = d;
  endtask

  function automatic logic [63:0] make_tag(input int set_nz);
    logic [63:0] t;
    t = next_rand();
    if (set_nz == 0) t[12:0] = 13'd0;
    else if (t[12:0] == 13'd0) t[0] = 1'b1;
    return t;
  endfunction

  // Watchdog
  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] e;
    logic [63:0] t;
    tests = 0; fails = 0; done = 1'b0;
    lcg = 64'h1234_5678_9abc_def1;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; tag_access = '0;
    for (int i = 0; i < 12; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rd_data after reset", rd_data, 64'd0);
    for (int sd = 0; sd < 2; sd++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < 3; k++) begin
          do_read(raddr(sd, st, k), v);
          check("R1 register reset", v, 64'd0);
        end

    // R2: write and read back every register
    for (int sd = 0; sd < 2; sd++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < 3; k++) set_reg(sd, st, k, next_rand());
    for (int sd = 0; sd < 2; sd++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < 3; k++) begin
          do_read(raddr(sd, st, k), v);
          check("R2 readback", v, shadow[sidx(sd, st, k)]);
        end
    // R2: hold while rd_en low
    e = rd_data;
    repeat (5) @(negedge clk);
    check("R2 hold", rd_data, e);

    // R3: ignored writes
    for (int sd = 0; sd < 2; sd++)
      for (int st = 0; st < 2; st++) do_write(raddr(sd, st, 3), next_rand());
    do_write(paddr(0, 0), next_rand());
    do_write(paddr(1, 1), next_rand());
    do_write(5'b10110, next_rand());
    for (int sd = 0; sd < 2; sd++)
      for (int st = 0; st < 2; st++) begin
        for (int k = 0; k < 3; k++) begin
          do_read(raddr(sd, st, k), v);
          check("R3 register untouched", v, shadow[sidx(sd, st, k)]);
        end
        do_read(raddr(sd, st, 3), v);
        check("R3 reserved reads zero", v, 64'd0);
      end

    // R4: context selection, same tag page bits, zero vs nonzero context
    set_reg(0, 0, 0, 64'hAAAA_0000_0000_0003);
    set_reg(0, 1, 0, 64'h5555_0000_0000_0003);
    set_reg(0, 0, 2, 64'h0);
    set_reg(0, 1, 2, 64'h0);
    t = 64'h0000_0000_00FF_E000;
    tag_access = t;
    do_read(paddr(0, 0), v);
    check("R4 ctx zero set", v, exp_ptr(0, 0, t));
    t[12:0] = 13'h1000;
    tag_access = t;
    do_read(paddr(0, 0), v);
    check("R4 ctx nonzero set", v, exp_ptr(0, 0, t));

    // R5: high part and zero low bits
    set_reg(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0);
    set_reg(1, 0, 2, 64'h0);
    t = 64'hFFFF_FFFF_FFFF_E000;
    tag_access = t;
    do_read(paddr(1, 0), v);
    check("R5 low nibble zero", {60'd0, v[3:0]}, 64'd0);
    check("R5 pointer value", v, exp_ptr(1, 0, t));

    // R7: split affects slot 1 only
    set_reg(1, 0, 1, 64'h0000_0000_0010_1005);
    set_reg(1, 0, 0, 64'h0000_0000_0010_1005);
    t = 64'h0;
    tag_access = t;
    do_read(paddr(1, 1), v);
    check("R7 split bit on slot 1", v, 64'h0000_0000_0014_0000);
    do_read(paddr(1, 0), v);
    check("R7 slot 0 ignores split", v, 64'h0000_0000_0010_0000);

    // R8: side independence
    set_reg(0, 0, 1, 64'h0000_1111_0000_0000);
    set_reg(1, 0, 1, 64'h0000_2222_0000_0000);
    tag_access = 64'h0;
    do_read(paddr(0, 1), v);
    check("R8 data side", v, 64'h0000_1111_0000_0000);
    do_read(paddr(1, 1), v);
    check("R8 instruction side", v, 64'h0000_2222_0000_0000);

    // R9: write and pointer read in the same cycle
    set_reg(0, 0, 0, 64'h0000_0000_1234_0002);
    t = 64'h0000_0000_0ABC_0000;
    tag_access = t;
    e = exp_ptr(0, 0, t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = raddr(0, 0, 0); wr_data = 64'h0000_0000_9870_0002;
    rd_en = 1'b1; rd_addr = paddr(0, 0);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    shadow[sidx(0, 0, 0)] = 64'h0000_0000_9870_0002;
    check("R9 read sees old contents", rd_data, e);
    do_read(paddr(0, 0), v);
    check("R9 next read sees new contents", v, exp_ptr(0, 0, t));

    // R6 sweep: table size x page code x side x set x split, both slots
    for (int sz = 0; sz < 16; sz++)
      for (int ps = 0; ps < 8; ps++)
        for (int sd = 0; sd < 2; sd++)
          for (int st = 0; st < 2; st++)
            for (int sp = 0; sp < 2; sp++) begin
              logic [63:0] b0;
              logic [63:0] b1;
              logic [63:0] cf;
              b0 = next_rand(); b0[3:0] = sz[3:0];
              b1 = next_rand(); b1[3:0] = 4'(15 - sz); b1[12] = sp[0];
              cf = next_rand(); cf[2:0] = ps[2:0]; cf[10:8] = 3'(7 - ps);
              set_reg(sd, st, 0, b0);
              set_reg(sd, st, 1, b1);
              set_reg(sd, st, 2, cf);
              t = make_tag(st);
              tag_access = t;
              do_read(paddr(sd, 0), v);
              check("R6 sweep slot 0", v, exp_ptr(sd, 0, t));
              do_read(paddr(sd, 1), v);
              check("R6 sweep slot 1", v, exp_ptr(sd, 1, t));
            end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule